// File: doc/BRIEF.md
# Serial-Access Real-Time Counter Register Bank

This block is the remote end of a three-wire serial link (clock, enable, data in) with one return data line. It keeps a free-running 32-bit seconds counter, a 32-bit seconds adjust word and four 32-bit retained scratch words. The host clocks transactions in on its own serial clock. The block brings all three link inputs into the system clock domain and detects serial clock edges there.

While the enable line is high, every rising serial clock edge shifts one data bit in, most significant bit first. The first rising edge with enable low is the direction bit. A 1 commits the 32 data bits to the 3-bit address that was shifted last. A 0 starts a read, which returns the addressed register on the return line over the next 32 clock pulses.

The link state machine has three states:
- IDLE waits for a transaction. IDLE goes to SHIFT on a rising edge with enable high.
- SHIFT collects bits. On the direction edge it goes back to IDLE for a write, or on to READ for a read.
- READ drives out one bit per rising edge. It returns to IDLE after the 32nd edge, or moves to SHIFT when a new enable-high edge arrives.

A one-cycle tick input advances the counter once per second.

Top module: `rtc_serial_bank`

## Requirements
- R1: SDI is sampled on rising SCLK edges. While SEN is high, each sampled bit is shifted in MSB first. For a write the host sends 32 data bits and then 3 address bits, so the last 3 bits are the address and the 32 bits before them are the data.
- R2: The first rising SCLK edge with SEN low after shifting is the direction bit. When SDI is 1 on that edge, the captured data is written to the addressed register.
- R3: When SDI is 0 on the direction edge, the addressed register is captured. After the k-th following rising SCLK edge (k = 1..32), SDO carries bit 32-k of that value, MSB first.
- R4: Address 0 is the seconds counter, readable and writable.
- R5: Address 2 is the seconds adjust word, readable and writable.
- R6: Addresses 4 to 7 are four independent retained 32-bit words, readable and writable.
- R7: Writes to addresses 1 and 3 change no register, and reads from them return zero.
- R8: Each cycle with the tick input high increments the counter by one. The counter wraps from 0xFFFFFFFF to 0.
- R9: A serial write to the counter that commits in the same cycle as a tick loads the written value, and the tick is lost.
- R10: Ready is high only when the link is idle and SEN is low. It is low while SEN is high and while a read is still shifting out.
- R11: After reset, all registers are zero, SDO is 0 and ready is 1.
- R12: Rising SCLK edges with SEN low while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle seconds tick |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| sen_i | input | 1 | Serial enable from the host (asynchronous) |
| sdi_i | input | 1 | Serial data from the host (asynchronous) |
| sdo_o | output | 1 | Serial read data to the host |
| ready_o | output | 1 | Link idle and able to accept a transfer |

## Verification
A wrong shift position or a wrong address decode shows up at the ports as a misplaced or foreign value. That value appears on SDO in the first read after the faulty write, on the pulse whose bit is wrong. A state machine stuck in SHIFT or READ shows up as ready staying low right after the transaction ends. A wrong counter increment, wrap or priority shows up as a wrong value in the next counter read-back.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_READ  = 2'd2
    } link_state_e;
endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] last_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            last_q <= stage_q[STAGES-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rtc_link_fsm.sv
module rtc_link_fsm
    import rtc_bank_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sen,
    input  logic          sdi,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          ready
);
    localparam int SH_W  = DW + AW;
    localparam int CNT_W = $clog2(DW + 1);

    link_state_e state_q, state_d;
    logic [SH_W-1:0]  shift_q;
    logic [DW-1:0]    out_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sdo_q;
    logic             dir_edge, last_pulse;

    assign dir_edge   = sclk_rise && !sen && (state_q == ST_SHIFT);
    assign last_pulse = (cnt_q == CNT_W'(DW - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sclk_rise && sen) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (dir_edge) state_d = sdi ? ST_IDLE : ST_READ;
            end
            ST_READ: begin
                if (sclk_rise && sen)             state_d = ST_SHIFT;
                else if (sclk_rise && last_pulse) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            out_q   <= '0;
            cnt_q   <= '0;
            sdo_q   <= 1'b0;
        end else begin
            if (sclk_rise && sen) begin
                shift_q <= {shift_q[SH_W-2:0], sdi};
            end
            if (dir_edge && !sdi) begin
                out_q <= rd_data;
                cnt_q <= '0;
            end else if (sclk_rise && !sen && state_q == ST_READ) begin
                sdo_q <= out_q[DW-1];
                out_q <= {out_q[DW-2:0], 1'b0};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        ready   = 1'b0;
        addr    = shift_q[AW-1:0];
        wr_data = shift_q[SH_W-1:AW];
        sdo     = sdo_q;
        unique case (state_q)
            ST_IDLE:  ready = !sen;
            ST_SHIFT: wr_en = dir_edge && sdi;
            ST_READ:  ready = 1'b0;
            default:  ready = 1'b0;
        endcase
    end

    a_r2_write_only_from_shift: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state_q == ST_IDLE));
    a_r3_read_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && sclk_rise && !sen && last_pulse) |=> (state_q == ST_IDLE));
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && sen) |=> !ready);
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
    import rtc_bank_pkg::*;
#(
    parameter int DW        = DATA_W,
    parameter int AW        = ADDR_W,
    parameter int SCRATCH_N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam logic [AW-1:0] A_COUNT = AW'(0);
    localparam logic [AW-1:0] A_ADJ   = AW'(2);
    localparam int            S_BASE  = 4;

    logic [DW-1:0] count_q, adj_q;
    logic [DW-1:0] scratch_q [SCRATCH_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        count_q <= '0;
        else if (wr_en && addr == A_COUNT) count_q <= wr_data;
        else if (tick)                     count_q <= count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      adj_q <= '0;
        else if (wr_en && addr == A_ADJ) adj_q <= wr_data;
    end

    generate
        for (genvar i = 0; i < SCRATCH_N; i++) begin : g_scratch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              scratch_q[i] <= '0;
                else if (wr_en && addr == AW'(S_BASE + i)) scratch_q[i] <= wr_data;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (addr == A_COUNT) rd_data = count_q;
        if (addr == A_ADJ)   rd_data = adj_q;
        for (int i = 0; i < SCRATCH_N; i++) begin
            if (addr == AW'(S_BASE + i)) rd_data = scratch_q[i];
        end
    end

    a_r8_tick_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && addr == A_COUNT)) |=> (count_q == $past(count_q) + 1'b1));
    a_r9_write_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_COUNT) |=> (count_q == $past(wr_data)));
    a_r7_hole_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == AW'(1) || addr == AW'(3)) && !tick) |=> ($stable(count_q) && $stable(adj_q)));
endmodule

// File: rtl/rtc_serial_bank.sv
module rtc_serial_bank
    import rtc_bank_pkg::*;
#(
    parameter int DW          = DATA_W,
    parameter int AW          = ADDR_W,
    parameter int SCRATCH_N   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sclk_i,
    input  logic sen_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic ready_o
);
    logic [2:0]    pins_s, pins_r;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data, rd_data;

    rtc_edge_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sen_i, sclk_i}),
        .sync_o  (pins_s),
        .rise_o  (pins_r)
    );

    rtc_link_fsm #(.DW(DW), .AW(AW)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (pins_r[0]),
        .sen       (pins_s[1]),
        .sdi       (pins_s[2]),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .sdo       (sdo_o),
        .ready     (ready_o)
    );

    rtc_reg_bank #(.DW(DW), .AW(AW), .SCRATCH_N(SCRATCH_N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );
endmodule

// File: tb/rtc_serial_bank_test.sv
module rtc_serial_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic clk = 0, rst_n = 0, tick_i = 0, sclk_i = 0, sen_i = 0, sdi_i = 0;
    logic sdo_o, ready_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_serial_bank uut (.clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sclk_i(sclk_i),
                         .sen_i(sen_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .ready_o(ready_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sclk_i = 0; sdi_i = b; wait_n(HALF);
        sclk_i = 1; wait_n(HALF);
    endtask

    task automatic ser_write(input logic [2:0] a, input logic [31:0] d);
        sen_i = 1;
        for (int i = 31; i >= 0; i--) pulse(d[i]);
        for (int i = 2; i >= 0; i--) pulse(a[i]);
        sen_i = 0;
        pulse(1'b1);
        sclk_i = 0; sdi_i = 0; wait_n(HALF);
    endtask

    task automatic ser_read(input logic [2:0] a, output logic [31:0] d);
        sen_i = 1;
        for (int i = 2; i >= 0; i--) pulse(a[i]);
        sen_i = 0;
        pulse(1'b0);
        for (int i = 31; i >= 0; i--) begin
            pulse(1'b0);
            d[i] = sdo_o;
        end
        sclk_i = 0; wait_n(HALF);
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1; wait_n(1); tick_i = 0; wait_n(1);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R11 ready", {31'b0, ready_o}, 32'd1);
        chk("R11 sdo", {31'b0, sdo_o}, 32'd0);
        ser_read(3'd0, v); chk("R11 counter", v, 32'd0);
        ser_read(3'd6, v); chk("R11 scratch", v, 32'd0);
    endtask

    task automatic t_counter_rw;
        logic [31:0] v;
        ser_write(3'd0, 32'h8001_7FFE);
        ser_read(3'd0, v); chk("R4 R1 R2 R3 counter", v, 32'h8001_7FFE);
        ser_write(3'd2, 32'hA5C3_0F96);
        ser_read(3'd2, v); chk("R5 adjust", v, 32'hA5C3_0F96);
    endtask

    task automatic t_scratch;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) ser_write(3'(4 + i), 32'h1111_0000 * (i + 1) + 32'(i * 7 + 1));
        for (int i = 0; i < 4; i++) begin
            ser_read(3'(4 + i), v);
            chk("R6 scratch", v, 32'h1111_0000 * (i + 1) + 32'(i * 7 + 1));
        end
    endtask

    task automatic t_holes;
        logic [31:0] v;
        ser_write(3'd1, 32'hDEAD_BEEF);
        ser_write(3'd3, 32'hCAFE_F00D);
        ser_read(3'd1, v); chk("R7 read 1", v, 32'd0);
        ser_read(3'd3, v); chk("R7 read 3", v, 32'd0);
        ser_read(3'd0, v); chk("R7 counter kept", v, 32'h8001_7FFE);
        ser_read(3'd2, v); chk("R7 adjust kept", v, 32'hA5C3_0F96);
    endtask

    task automatic t_ticks;
        logic [31:0] v;
        ser_write(3'd0, 32'hFFFF_FFFE);
        give_ticks(3);
        ser_read(3'd0, v); chk("R8 wrap", v, 32'd1);
        give_ticks(5);
        ser_read(3'd0, v); chk("R8 count", v, 32'd6);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        sen_i = 1;
        for (int i = 31; i >= 0; i--) pulse(1'(32'h0000_1234 >> i));
        for (int i = 2; i >= 0; i--) pulse(1'b0);
        sen_i = 0;
        sclk_i = 0; sdi_i = 1; wait_n(HALF);
        sclk_i = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) tick_i = 1;
        @(negedge clk) tick_i = 0;
        wait_n(HALF);
        sclk_i = 0; sdi_i = 0; wait_n(HALF);
        ser_read(3'd0, v); chk("R9 write wins", v, 32'h0000_1234);
    endtask

    task automatic t_ready;
        sen_i = 1;
        pulse(1'b1);
        chk("R10 busy", {31'b0, ready_o}, 32'd0);
        pulse(1'b0); pulse(1'b0);
        sen_i = 0;
        pulse(1'b0);
        pulse(1'b0);
        chk("R10 reading", {31'b0, ready_o}, 32'd0);
        for (int i = 0; i < 31; i++) pulse(1'b0);
        sclk_i = 0; wait_n(HALF);
        chk("R10 idle again", {31'b0, ready_o}, 32'd1);
    endtask

    task automatic t_stray;
        logic [31:0] v;
        for (int i = 0; i < 5; i++) pulse(1'b1);
        sclk_i = 0; wait_n(HALF);
        chk("R12 ready", {31'b0, ready_o}, 32'd1);
        ser_read(3'd5, v); chk("R12 scratch kept", v, 32'h2222_0008);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1;
        wait_n(4);
        t_reset();
        t_counter_rw();
        t_scratch();
        t_holes();
        t_ticks();
        t_priority();
        t_ready();
        t_stray();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule